// File: doc/BRIEF.md
# Extended multiply-accumulate register unit

This block keeps the result registers of a 32-bit multiplier: a main HI/LO pair topped by an 8-bit guard byte (ACX), so that ACX|HI|LO behaves as one 72-bit accumulator, plus three further HI/LO pairs that have no guard byte. A request names an operation, an accumulator index and two 32-bit operands. The operations are unsigned multiply, signed multiply, unsigned multiply-add, a write of HI, a write of LO, a left move that pushes a word into LO, and a right move that pulls the old LO out as the extracted word.

The guard byte counts carries out of the 64-bit pair during unsigned multiply-add on the main pair. This lets long unsigned dot products run without losing overflow. Unsigned multiply clears the byte. Signed multiply and the HI/LO writes leave it alone. The two word moves carry data through the whole chain on the main pair and through HI/LO only on the other pairs. Each request is a one-cycle strobe, and its effect is visible after the next rising clock edge. A separate view select picks which pair appears on the HI/LO outputs.

Top module: `macc_ext_unit`

## Requirements
- R1: Opcode 0 (unsigned multiply) loads the selected pair with the unsigned 64-bit product of A and B, HI taking bits 63:32 and LO bits 31:0. On index 0 it also clears ACX.
- R2: Opcode 1 (signed multiply) loads the selected pair with the two's-complement 64-bit product of A and B, and leaves ACX unchanged.
- R3: Opcode 2 (unsigned multiply-add) replaces the selected {HI,LO} with {HI,LO} + A*B modulo 2^64, both operands unsigned.
- R4: On index 0, opcode 2 adds one to ACX exactly when the 64-bit sum wraps, that is when the new {HI,LO} is below the old one. ACX is 8 bits wide and goes from 255 to 0.
- R5: Opcode 3 writes A into HI and opcode 4 writes A into LO of the selected pair. The other half of the pair and ACX keep their values.
- R6: Opcode 5 (push) on index 0 moves the chain up by 32 bits: ACX takes HI bits 7:0, HI takes LO, LO takes A, and the bits above ACX are dropped. On another index, HI takes LO and LO takes A.
- R7: Opcode 6 (pull) loads the extracted word with the old LO of the selected pair. On index 0, LO takes HI, HI takes ACX zero-extended, and ACX becomes 0. On another index, LO takes HI and HI becomes 0.
- R8: A request with an index other than 0 changes only that pair and never changes ACX.
- R9: A cycle with the valid strobe low, or a request with opcode 7, changes no pair, ACX or extracted word.
- R10: A low rst_n at a rising edge clears every pair, ACX and the extracted word.
- R11: The extracted word keeps its value until the next pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe |
| req_op | input | 3 | Operation code (0 to 7) |
| req_idx | input | 2 | Accumulator index, 0 is the main pair with ACX |
| req_a | input | 32 | First operand, or the word to write or push |
| req_b | input | 32 | Second operand |
| view_sel | input | 2 | Pair shown on hi_out and lo_out |
| hi_out | output | 32 | HI of the viewed pair |
| lo_out | output | 32 | LO of the viewed pair |
| acx_out | output | 8 | Guard byte of the main pair |
| ext_word | output | 32 | Word returned by the last pull |

## Verification
The hardest state to reach from the ports is a guard byte that sits at 255 just before a multiply-add that carries, because the count of carries must not move when nothing wraps. The bench writes 0xFF into HI and pushes it up into ACX. It then writes all ones into the pair and issues a multiply-add of 1 by 1, which must wrap both the pair and the byte to zero. Before that, sweeps of multiply and multiply-add over operands picked at the edges of the signed and unsigned ranges run against a bench model. These sweeps mix in carry-free sums, so a guard byte that counts on the wrong condition is caught.

// File: rtl/macc_ext_pkg.sv
// Package for the extended multiply-accumulate unit.
// Holds the operation codes. The encoding is part of the request interface.
package macc_ext_pkg;

    typedef enum logic [2:0] {
        OP_MULU  = 3'd0,
        OP_MULS  = 3'd1,
        OP_MADDU = 3'd2,
        OP_SETHI = 3'd3,
        OP_SETLO = 3'd4,
        OP_PUSH  = 3'd5,
        OP_PULL  = 3'd6,
        OP_IDLE  = 3'd7
    } macc_op_e;

endpackage

// File: rtl/macc_ext_datapath.sv
// Next-state datapath of the extended multiply-accumulate unit.
// It is purely combinational. From the addressed pair, the guard byte and the
// request, it computes the new pair, the new guard byte and the extracted
// word. It assumes ACXW <= W. The guard byte changes only when is_main is set.
module macc_ext_datapath
    import macc_ext_pkg::*;
#(
    parameter int W    = 32,
    parameter int ACXW = 8
) (
    input  macc_op_e        op,
    input  logic            is_main,
    input  logic [W-1:0]    opa,
    input  logic [W-1:0]    opb,
    input  logic [W-1:0]    cur_hi,
    input  logic [W-1:0]    cur_lo,
    input  logic [ACXW-1:0] cur_acx,
    output logic [W-1:0]    nxt_hi,
    output logic [W-1:0]    nxt_lo,
    output logic [ACXW-1:0] nxt_acx,
    output logic            ext_load,
    output logic [W-1:0]    ext_val
);
    localparam int DW = 2 * W;

    logic [DW-1:0]        pair_now;
    logic [DW-1:0]        prod_u;
    logic [DW-1:0]        prod_s;
    logic [DW-1:0]        sum_u;
    logic                 wrap;
    logic signed [DW-1:0] sa;
    logic signed [DW-1:0] sb;

    // Form both products and the accumulate sum with its wrap flag
    always_comb begin
        pair_now = {cur_hi, cur_lo};
        prod_u   = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};
        sa       = {{W{opa[W-1]}}, opa};
        sb       = {{W{opb[W-1]}}, opb};
        prod_s   = sa * sb;
        sum_u    = pair_now + prod_u;
        wrap     = (sum_u < pair_now);
    end

    // Select the next register contents for the requested operation
    always_comb begin
        nxt_hi   = cur_hi;
        nxt_lo   = cur_lo;
        nxt_acx  = cur_acx;
        ext_load = 1'b0;
        ext_val  = cur_lo;
        unique case (op)
            OP_MULU: begin
                {nxt_hi, nxt_lo} = prod_u;
                if (is_main) nxt_acx = '0;
            end
            OP_MULS: begin
                {nxt_hi, nxt_lo} = prod_s;
            end
            OP_MADDU: begin
                {nxt_hi, nxt_lo} = sum_u;
                if (is_main && wrap) nxt_acx = cur_acx + 1'b1;
            end
            OP_SETHI: nxt_hi = opa;
            OP_SETLO: nxt_lo = opa;
            OP_PUSH: begin
                if (is_main) nxt_acx = cur_hi[ACXW-1:0];
                nxt_hi = cur_lo;
                nxt_lo = opa;
            end
            OP_PULL: begin
                ext_load = 1'b1;
                nxt_lo   = cur_hi;
                if (is_main) begin
                    nxt_hi  = {{(W-ACXW){1'b0}}, cur_acx};
                    nxt_acx = '0;
                end else begin
                    nxt_hi  = '0;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/macc_ext_pair.sv
// A single HI/LO register pair.
// It loads both halves when the write enable is high and is cleared by the
// synchronous active-low reset. It assumes the caller gives the unchanged
// half when only one half is meant to change.
module macc_ext_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d_hi,
    input  logic [W-1:0] d_lo,
    output logic [W-1:0] q_hi,
    output logic [W-1:0] q_lo
);
    // Hold or load the pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_hi <= '0;
            q_lo <= '0;
        end else if (we) begin
            q_hi <= d_hi;
            q_lo <= d_lo;
        end
    end

endmodule

// File: rtl/macc_ext_unit.sv
// Top of the extended multiply-accumulate unit.
// It holds NACC HI/LO pairs, a guard byte above pair 0 and the extracted
// word register. Each valid request updates the addressed pair and, on pair 0,
// the guard byte at the next rising edge. The pair chosen by view_sel is
// shown combinationally. It assumes that NACC >= 2 and that ACXW <= W.
module macc_ext_unit
    import macc_ext_pkg::*;
#(
    parameter int W    = 32,
    parameter int ACXW = 8,
    parameter int NACC = 4,
    localparam int IDXW = $clog2(NACC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [IDXW-1:0] req_idx,
    input  logic [W-1:0]    req_a,
    input  logic [W-1:0]    req_b,
    input  logic [IDXW-1:0] view_sel,
    output logic [W-1:0]    hi_out,
    output logic [W-1:0]    lo_out,
    output logic [ACXW-1:0] acx_out,
    output logic [W-1:0]    ext_word
);
    logic [W-1:0]    bank_hi [NACC];
    logic [W-1:0]    bank_lo [NACC];
    logic [W-1:0]    sel_hi;
    logic [W-1:0]    sel_lo;
    logic [W-1:0]    nxt_hi;
    logic [W-1:0]    nxt_lo;
    logic [ACXW-1:0] nxt_acx;
    logic [ACXW-1:0] acx_q;
    logic [W-1:0]    ext_q;
    logic            ext_load;
    logic [W-1:0]    ext_val;
    logic            is_main;
    macc_op_e        op_dec;

    // Decode the request and fetch the addressed pair
    always_comb begin
        op_dec  = macc_op_e'(req_op);
        is_main = (req_idx == '0);
        sel_hi  = bank_hi[req_idx];
        sel_lo  = bank_lo[req_idx];
    end

    macc_ext_datapath #(.W(W), .ACXW(ACXW)) u_dp (
        .op       (op_dec),
        .is_main  (is_main),
        .opa      (req_a),
        .opb      (req_b),
        .cur_hi   (sel_hi),
        .cur_lo   (sel_lo),
        .cur_acx  (acx_q),
        .nxt_hi   (nxt_hi),
        .nxt_lo   (nxt_lo),
        .nxt_acx  (nxt_acx),
        .ext_load (ext_load),
        .ext_val  (ext_val)
    );

    for (genvar g = 0; g < NACC; g++) begin : g_pair
        logic we_g;
        // Enable only the addressed pair on a valid request
        always_comb we_g = req_valid && (req_idx == IDXW'(g));
        macc_ext_pair #(.W(W)) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_g),
            .d_hi  (nxt_hi),
            .d_lo  (nxt_lo),
            .q_hi  (bank_hi[g]),
            .q_lo  (bank_lo[g])
        );
    end

    // Guard byte: only requests to pair 0 may change it
    always_ff @(posedge clk) begin
        if (!rst_n)                  acx_q <= '0;
        else if (req_valid && is_main) acx_q <= nxt_acx;
    end

    // Extracted word: loaded by a pull, otherwise held
    always_ff @(posedge clk) begin
        if (!rst_n)                    ext_q <= '0;
        else if (req_valid && ext_load) ext_q <= ext_val;
    end

    // Drive the outputs from the viewed pair and the registers
    always_comb begin
        hi_out   = bank_hi[view_sel];
        lo_out   = bank_lo[view_sel];
        acx_out  = acx_q;
        ext_word = ext_q;
    end

endmodule

// File: rtl/macc_ext_checker.sv
// Checker for the extended multiply-accumulate unit. It watches only the
// ports of the top module and is attached to it by the bind statement below.
module macc_ext_checker #(
    parameter int W    = 32,
    parameter int ACXW = 8,
    parameter int IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [IDXW-1:0] req_idx,
    input logic [IDXW-1:0] view_sel,
    input logic [W-1:0]    lo_out,
    input logic [ACXW-1:0] acx_out,
    input logic [W-1:0]    ext_word
);
    // R1
    mulu_clears_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd0 && req_idx == '0 |=> acx_out == '0);

    // R2
    muls_keeps_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd1 |=> $stable(acx_out));

    // R4
    maddu_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd2 && req_idx == '0
        |=> (acx_out == $past(acx_out)) || (acx_out == ACXW'($past(acx_out) + 1'b1)));

    // R5
    write_keeps_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_op == 3'd3 || req_op == 3'd4) |=> $stable(acx_out));

    // R7
    pull_returns_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd6 && req_idx == view_sel |=> ext_word == $past(lo_out));

    // R7
    pull_clears_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd6 && req_idx == '0 |=> acx_out == '0);

    // R8
    side_pair_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_idx != '0 |=> $stable(acx_out));

    // R9
    idle_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid || req_op == 3'd7 |=> $stable(acx_out) && $stable(ext_word));

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> acx_out == '0 && ext_word == '0);

    // R11
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op == 3'd6) |=> $stable(ext_word));

endmodule

bind macc_ext_unit macc_ext_checker #(.W(W), .ACXW(ACXW), .IDXW(IDXW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_idx   (req_idx),
    .view_sel  (view_sel),
    .lo_out    (lo_out),
    .acx_out   (acx_out),
    .ext_word  (ext_word)
);

// File: tb/macc_ext_unit_test.sv
`timescale 1ns/1ps
module macc_ext_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd7;
    logic [1:0]  req_idx = 2'd0;
    logic [31:0] req_a = '0;
    logic [31:0] req_b = '0;
    logic [1:0]  view_sel = 2'd0;
    logic [31:0] hi_out;
    logic [31:0] lo_out;
    logic [7:0]  acx_out;
    logic [31:0] ext_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_hi [4];
    logic [31:0] m_lo [4];
    logic [7:0]  m_acx;
    logic [31:0] m_ext;

    logic [31:0] vals [8] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF,
                              32'h8000_0000, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0001_0003};

    always #2 clk = ~clk;

    macc_ext_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_a(req_a), .req_b(req_b), .view_sel(view_sel),
        .hi_out(hi_out), .lo_out(lo_out), .acx_out(acx_out), .ext_word(ext_word)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_hi[i] = '0; m_lo[i] = '0; end
        m_acx = '0;
        m_ext = '0;
    endtask

    // Bench model of one request, written from the requirements
    task automatic model_op(input int op, input int idx, input logic [31:0] a,
                            input logic [31:0] b);
        logic [63:0] old_p, p;
        longint      sp;
        old_p = {m_hi[idx], m_lo[idx]};
        case (op)
            0: begin p = {32'h0, a} * {32'h0, b}; {m_hi[idx], m_lo[idx]} = p;
                     if (idx == 0) m_acx = '0; end
            1: begin sp = longint'($signed(a)) * longint'($signed(b));
                     {m_hi[idx], m_lo[idx]} = sp; end
            2: begin p = old_p + {32'h0, a} * {32'h0, b}; {m_hi[idx], m_lo[idx]} = p;
                     if (idx == 0 && p < old_p) m_acx = m_acx + 8'd1; end
            3: m_hi[idx] = a;
            4: m_lo[idx] = a;
            5: begin if (idx == 0) m_acx = m_hi[idx][7:0];
                     m_hi[idx] = m_lo[idx]; m_lo[idx] = a; end
            6: begin m_ext = m_lo[idx]; m_lo[idx] = m_hi[idx];
                     if (idx == 0) begin m_hi[idx] = {24'h0, m_acx}; m_acx = '0; end
                     else m_hi[idx] = '0; end
            default: ;
        endcase
    endtask

    // Compare all visible state with the model
    task automatic check_all(input string tag);
        for (int s = 0; s < 4; s++) begin
            view_sel = 2'(s);
            #0.2;
            chk(tag, $sformatf("hi[%0d]", s), hi_out, m_hi[s]);
            chk(tag, $sformatf("lo[%0d]", s), lo_out, m_lo[s]);
        end
        chk(tag, "acx", {24'h0, acx_out}, {24'h0, m_acx});
        chk(tag, "ext", ext_word, m_ext);
        view_sel = 2'd0;
    endtask

    task automatic run_op(input string tag, input int op, input int idx,
                          input logic [31:0] a, input logic [31:0] b, input bit vld = 1'b1);
        @(negedge clk);
        req_valid = vld; req_op = 3'(op); req_idx = 2'(idx); req_a = a; req_b = b;
        view_sel = 2'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        if (vld) model_op(op, idx, a, b);
        check_all(tag);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R10");

        // R1 R2 R3 R4: sweeps on the main pair
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
                run_op("R1", 0, 0, vals[i], vals[j]);
                run_op("R2", 1, 0, vals[j], vals[i]);
                run_op("R3", 2, 0, vals[i], vals[j]);
                run_op("R4", 2, 0, vals[j], vals[i]);
            end

        // R5: half writes keep the other half and ACX
        run_op("R5", 3, 0, 32'h1234_5678, 0);
        run_op("R5", 4, 0, 32'h9ABC_DEF0, 0);

        // R6: push chain, bits above ACX dropped
        run_op("R6", 3, 0, 32'hA5A5_A5C3, 0);
        run_op("R6", 5, 0, 32'h1111_2222, 0);
        run_op("R6", 5, 0, 32'h3333_4444, 0);

        // R7: pull chain with zero fill
        run_op("R7", 6, 0, 0, 0);
        run_op("R7", 6, 0, 0, 0);
        run_op("R7", 6, 0, 0, 0);

        // R4: guard byte at 255 wraps on a carrying multiply-add
        run_op("R4", 3, 0, 32'h0000_00FF, 0);
        run_op("R4", 5, 0, 32'hFFFF_FFFF, 0);
        run_op("R4", 3, 0, 32'hFFFF_FFFF, 0);
        run_op("R4", 2, 0, 32'h0, 32'h5);
        chk("R4", "acx before wrap", {24'h0, acx_out}, 32'hFF);
        run_op("R4", 2, 0, 32'h1, 32'h1);
        chk("R4", "acx after wrap", {24'h0, acx_out}, 32'h0);

        // R8: side pairs, guard byte made nonzero first
        run_op("R8", 3, 0, 32'h0000_0042, 0);
        run_op("R8", 5, 0, 32'h7, 0);
        for (int k = 1; k < 4; k++)
            for (int i = 0; i < 8; i++) begin
                run_op("R8", 0, k, vals[i], vals[7 - i]);
                run_op("R8", 2, k, 32'hFFFF_FFFF, vals[i]);
                run_op("R8", 1, k, vals[i], 32'hFFFF_FFFF);
                run_op("R8", 5, k, vals[i], 0);
                run_op("R8", 6, k, 0, 0);
                run_op("R8", 3 + (i % 2), k, vals[i], 0);
            end

        // R9: strobe low and opcode 7 have no effect
        run_op("R9", 0, 0, 32'h5, 32'h5, 1'b0);
        run_op("R9", 6, 0, 0, 0, 1'b0);
        run_op("R9", 7, 0, 32'h5, 32'h5);
        run_op("R9", 7, 2, 32'h5, 32'h5);

        // R11: extracted word held across other requests
        run_op("R11", 6, 1, 0, 0);
        run_op("R11", 0, 1, 32'h3, 32'h3);
        run_op("R11", 5, 0, 32'h9, 0);

        // R10: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R10");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule